// File: doc/BRIEF.md
# Uop Delivery Source Event Counter

This block is a single performance-monitoring counter that watches the stream of micro-operations entering a decode queue. Every cycle the front end reports how many uops the legacy decoder produced, how many the decoded-uop cache produced (each 0 to 4), whether the microcode sequencer is busy, and whether the queue is empty. A selection mask chooses which source classes contribute. A legacy delivery falls into one class when the sequencer is idle and another when it is busy, and the same holds for a cache delivery. The selected uops are summed into one per-cycle value.

A threshold field turns the counter from counting uops into counting cycles. With a zero threshold the per-cycle sum is accumulated. With a nonzero threshold only cycles whose sum reaches the threshold add one. An edge option adds one only when a qualifying episode begins. The counter is 48 bits wide, wraps to zero, has a synchronous clear, and has an enable input.

Episode tracking uses a three-state machine. The states are `Q_OFF` (counter disabled, no history), `Q_LOW` (enabled, last cycle did not qualify) and `Q_HIGH` (enabled, last cycle qualified). The transitions are:

- Any state goes to `Q_OFF` while the enable is low.
- From any state with the enable high, a qualifying cycle moves the machine to `Q_HIGH` and a non-qualifying cycle moves it to `Q_LOW`.
- An edge is counted on the transitions `Q_OFF`→`Q_HIGH` and `Q_LOW`→`Q_HIGH`.

Top module: `uop_src_counter`

## Requirements
- R1: After reset the count output is 0 and the episode history is false, so in edge mode the first qualifying cycle after reset counts as an edge.
- R2: Class mapping by mask bit position:
  - bit 2 selects legacy uops with the sequencer idle;
  - bit 3 selects cache uops with the sequencer idle;
  - bit 4 selects cache uops with the sequencer busy;
  - bit 5 selects legacy uops with the sequencer busy.
  - A class whose sequencer condition does not hold contributes 0.
- R3: Mask bits combine by adding the counts of every selected class, for example 0x18 (all cache), 0x24 (all legacy), 0x30 (all while busy) and 0x3c (everything). A mask with none of bits 1 to 5 set adds nothing.
- R4: Mask bit 1 adds 1 to the per-cycle sum in every cycle the queue-empty input is high.
- R5: With threshold 0 and edge mode off, each enabled cycle adds the selected sum to the count. The new value is visible after the next rising clock edge.
- R6: With a nonzero threshold N and edge mode off, each enabled cycle adds 1 if the selected sum is at least N, and 0 otherwise.
- R7: With edge mode on, a cycle qualifies when its sum is at least the threshold (a threshold of 0 acts as 1). The count adds 1 only on a qualifying cycle whose previous enabled cycle did not qualify.
- R8: A high clear zeroes the count at the next edge, takes priority over any increment, and leaves the episode history unchanged.
- R9: While enable is low the count holds and the history returns to false. The first qualifying cycle after re-enabling therefore counts as an edge.
- R10: The count wraps modulo 2^CNT_W.
- R11: A per-source count above 4 is treated as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Counting enable |
| clr | input | 1 | Synchronous counter clear |
| sel_mask | input | 8 | Source class selection mask |
| thresh | input | LANE_W (3) | Cycle-mode threshold, 0 = count uops |
| edge_en | input | 1 | Count only episode starts |
| legacy_uops | input | LANE_W (3) | Uops from legacy decoder this cycle |
| cache_uops | input | LANE_W (3) | Uops from decoded-uop cache this cycle |
| ms_busy | input | 1 | Microcode sequencer busy this cycle |
| q_empty | input | 1 | Decode queue empty this cycle |
| count | output | CNT_W (48) | Event count |

## Verification
A wrong class routing or a wrong mask decode shows at the count output one edge after the offending cycle, as a step of the wrong size. The vector table therefore checks the count after every single stimulus cycle. A wrong episode state is invisible until the next qualifying cycle, when it shows as a missing or extra increment. For this reason the directed tests drive qualifying cycles right after a clear, after a disable and after a quiet cycle.

// File: rtl/uds_pkg.sv
package uds_pkg;

    // Mask bit positions: the class order below is decoded by software
    localparam int unsigned MASK_BIT_EMPTY   = 1;
    localparam int unsigned MASK_CLASS_BASE  = 2;
    localparam int unsigned NUM_CLASSES      = 4;

    // Class index inside the sorted vector (mask bit = base + index)
    localparam int unsigned CLS_LEGACY_FREE  = 0;
    localparam int unsigned CLS_CACHE_FREE   = 1;
    localparam int unsigned CLS_CACHE_MS     = 2;
    localparam int unsigned CLS_LEGACY_MS    = 3;

    typedef enum logic [1:0] {
        Q_OFF  = 2'd0,
        Q_LOW  = 2'd1,
        Q_HIGH = 2'd2
    } qual_state_e;

endpackage

// File: rtl/uds_lane_sort.sv
module uds_lane_sort
    import uds_pkg::*;
#(
    parameter int unsigned LANE_MAX = 4,
    parameter int unsigned LANE_W   = 3
) (
    input  logic [LANE_W-1:0]                  legacy_uops,
    input  logic [LANE_W-1:0]                  cache_uops,
    input  logic                               ms_busy,
    output logic [NUM_CLASSES-1:0][LANE_W-1:0] class_cnt
);

    localparam int unsigned NUM_SRC = 2;
    localparam logic [LANE_W-1:0] LANE_CAP = LANE_W'(LANE_MAX);

    logic [NUM_SRC-1:0][LANE_W-1:0] raw;
    logic [NUM_SRC-1:0][LANE_W-1:0] capped;

    assign raw[0] = legacy_uops;
    assign raw[1] = cache_uops;

    // Clamp each source to the lane limit
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_clamp
        assign capped[g] = (raw[g] > LANE_CAP) ? LANE_CAP : raw[g];
    end

    always_comb begin
        class_cnt = '0;
        if (ms_busy) begin
            class_cnt[CLS_LEGACY_MS] = capped[0];
            class_cnt[CLS_CACHE_MS]  = capped[1];
        end else begin
            class_cnt[CLS_LEGACY_FREE] = capped[0];
            class_cnt[CLS_CACHE_FREE]  = capped[1];
        end
    end

endmodule

// File: rtl/uds_mask_sum.sv
module uds_mask_sum
    import uds_pkg::*;
#(
    parameter int unsigned LANE_W = 3,
    parameter int unsigned MASK_W = 8,
    parameter int unsigned SUM_W  = 4
) (
    input  logic [NUM_CLASSES-1:0][LANE_W-1:0] class_cnt,
    input  logic                               q_empty,
    input  logic [MASK_W-1:0]                  sel_mask,
    output logic [SUM_W-1:0]                   sel_sum
);

    logic [NUM_CLASSES-1:0][SUM_W-1:0] term;
    logic [SUM_W-1:0]                  empty_term;

    // Each class contributes only when its mask bit is set
    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_term
        assign term[g] = sel_mask[MASK_CLASS_BASE + g] ? SUM_W'(class_cnt[g]) : '0;
    end

    assign empty_term = (sel_mask[MASK_BIT_EMPTY] && q_empty) ? SUM_W'(1) : '0;

    always_comb begin
        sel_sum = empty_term;
        for (int i = 0; i < int'(NUM_CLASSES); i++) begin
            sel_sum = sel_sum + term[i];
        end
    end

    logic unused_mask_bits;
    assign unused_mask_bits = ^{sel_mask[0], sel_mask[MASK_W-1:MASK_CLASS_BASE+NUM_CLASSES]};

endmodule

// File: rtl/uds_qualifier.sv
module uds_qualifier
    import uds_pkg::*;
#(
    parameter int unsigned SUM_W = 4,
    parameter int unsigned THR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             edge_en,
    input  logic [THR_W-1:0] thresh,
    input  logic [SUM_W-1:0] sel_sum,
    output logic [SUM_W-1:0] inc
);

    localparam int unsigned CMP_W = (SUM_W > THR_W) ? SUM_W : THR_W;

    qual_state_e state_q;
    qual_state_e state_d;

    logic [CMP_W-1:0] sum_w;
    logic [CMP_W-1:0] thr_w;
    logic             thr_zero;
    logic             qualifies;

    assign sum_w    = CMP_W'(sel_sum);
    assign thr_w    = CMP_W'(thresh);
    assign thr_zero = (thresh == '0);
    // A zero threshold behaves as one for cycle/edge qualification
    assign qualifies = thr_zero ? (sum_w != '0) : (sum_w >= thr_w);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and increment
    always_comb begin
        state_d = state_q;
        inc     = '0;
        unique case (state_q)
            Q_OFF, Q_LOW: begin
                if (!en) begin
                    state_d = Q_OFF;
                end else if (qualifies) begin
                    state_d = Q_HIGH;
                    if (edge_en) inc = SUM_W'(1);
                end else begin
                    state_d = Q_LOW;
                end
            end
            Q_HIGH: begin
                if (!en) begin
                    state_d = Q_OFF;
                end else if (qualifies) begin
                    state_d = Q_HIGH;
                end else begin
                    state_d = Q_LOW;
                end
            end
            default: begin
                state_d = Q_OFF;
            end
        endcase
        if (en && !edge_en) begin
            if (thr_zero) begin
                inc = sel_sum;
            end else begin
                inc = qualifies ? SUM_W'(1) : '0;
            end
        end
    end

endmodule

// File: rtl/uds_accum.sv
module uds_accum #(
    parameter int unsigned CNT_W = 48,
    parameter int unsigned SUM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SUM_W-1:0] inc,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + CNT_W'(inc);
        end
    end

    assign count = count_q;

endmodule

// File: rtl/uop_src_counter.sv
module uop_src_counter
    import uds_pkg::*;
#(
    parameter int unsigned CNT_W    = 48,
    parameter int unsigned LANE_MAX = 4,
    parameter int unsigned LANE_W   = $clog2(LANE_MAX + 1),
    parameter int unsigned THR_W    = LANE_W,
    parameter int unsigned MASK_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic [MASK_W-1:0] sel_mask,
    input  logic [THR_W-1:0]  thresh,
    input  logic              edge_en,
    input  logic [LANE_W-1:0] legacy_uops,
    input  logic [LANE_W-1:0] cache_uops,
    input  logic              ms_busy,
    input  logic              q_empty,
    output logic [CNT_W-1:0]  count
);

    localparam int unsigned SUM_W = $clog2(2 * LANE_MAX + 2);

    logic [NUM_CLASSES-1:0][LANE_W-1:0] class_cnt;
    logic [SUM_W-1:0]                   sel_sum;
    logic [SUM_W-1:0]                   inc;

    uds_lane_sort #(
        .LANE_MAX (LANE_MAX),
        .LANE_W   (LANE_W)
    ) i_sort (
        .legacy_uops (legacy_uops),
        .cache_uops  (cache_uops),
        .ms_busy     (ms_busy),
        .class_cnt   (class_cnt)
    );

    uds_mask_sum #(
        .LANE_W (LANE_W),
        .MASK_W (MASK_W),
        .SUM_W  (SUM_W)
    ) i_sum (
        .class_cnt (class_cnt),
        .q_empty   (q_empty),
        .sel_mask  (sel_mask),
        .sel_sum   (sel_sum)
    );

    uds_qualifier #(
        .SUM_W (SUM_W),
        .THR_W (THR_W)
    ) i_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .edge_en (edge_en),
        .thresh  (thresh),
        .sel_sum (sel_sum),
        .inc     (inc)
    );

    uds_accum #(
        .CNT_W (CNT_W),
        .SUM_W (SUM_W)
    ) i_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .inc   (inc),
        .count (count)
    );

endmodule

// File: rtl/uds_checker.sv
module uds_checker #(
    parameter int unsigned CNT_W = 48,
    parameter int unsigned THR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             clr,
    input logic             edge_en,
    input logic [THR_W-1:0] thresh,
    input logic [CNT_W-1:0] count
);

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    assert_hold_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> (count == $past(count)));

    assert_edge_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && edge_en && !clr) |=> ((count - $past(count)) <= CNT_W'(1)));

    assert_cycle_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (thresh != '0) && !clr) |=> ((count - $past(count)) <= CNT_W'(1)));

    // R5: one cycle adds at most two full lanes plus the empty bit
    assert_step_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> ((count - $past(count)) <= CNT_W'(9)));

endmodule

bind uop_src_counter uds_checker #(
    .CNT_W (CNT_W),
    .THR_W (THR_W)
) i_uds_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .clr     (clr),
    .edge_en (edge_en),
    .thresh  (thresh),
    .count   (count)
);

// File: tb/test_uop_src_counter.sv
module test_uop_src_counter;

    localparam int NV = 19;
    localparam int NARROW_W = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        clr = 1'b0;
    logic [7:0]  sel_mask = '0;
    logic [2:0]  thresh = '0;
    logic        edge_en = 1'b0;
    logic [2:0]  legacy_uops = '0;
    logic [2:0]  cache_uops = '0;
    logic        ms_busy = 1'b0;
    logic        q_empty = 1'b0;
    logic [47:0] count;
    logic [NARROW_W-1:0] count_n;

    int checks = 0;
    int fails  = 0;
    logic [47:0] exp_total = '0;

    always #2 clk = ~clk;

    uop_src_counter i_uop_src_counter (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .sel_mask(sel_mask),
        .thresh(thresh), .edge_en(edge_en), .legacy_uops(legacy_uops),
        .cache_uops(cache_uops), .ms_busy(ms_busy), .q_empty(q_empty),
        .count(count)
    );

    uop_src_counter #(.CNT_W(NARROW_W)) i_uop_src_counter_narrow (
        .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .sel_mask(sel_mask),
        .thresh(thresh), .edge_en(edge_en), .legacy_uops(legacy_uops),
        .cache_uops(cache_uops), .ms_busy(ms_busy), .q_empty(q_empty),
        .count(count_n)
    );

    // {mask, thresh, legacy, cache, busy, empty, expected increment}
    localparam logic [22:0] VEC [NV] = '{
        {8'h04, 3'd0, 3'd3, 3'd2, 1'b0, 1'b0, 4'd3},
        {8'h08, 3'd0, 3'd3, 3'd2, 1'b0, 1'b0, 4'd2},
        {8'h10, 3'd0, 3'd3, 3'd2, 1'b1, 1'b0, 4'd2},
        {8'h20, 3'd0, 3'd3, 3'd2, 1'b1, 1'b0, 4'd3},
        {8'h04, 3'd0, 3'd3, 3'd2, 1'b1, 1'b0, 4'd0},
        {8'h18, 3'd0, 3'd1, 3'd4, 1'b0, 1'b0, 4'd4},
        {8'h18, 3'd0, 3'd1, 3'd4, 1'b1, 1'b0, 4'd4},
        {8'h24, 3'd0, 3'd4, 3'd1, 1'b1, 1'b0, 4'd4},
        {8'h30, 3'd0, 3'd2, 3'd3, 1'b1, 1'b0, 4'd5},
        {8'h30, 3'd0, 3'd2, 3'd3, 1'b0, 1'b0, 4'd0},
        {8'h3c, 3'd0, 3'd4, 3'd4, 1'b1, 1'b0, 4'd8},
        {8'h02, 3'd0, 3'd0, 3'd0, 1'b0, 1'b1, 4'd1},
        {8'h02, 3'd0, 3'd3, 3'd3, 1'b0, 1'b0, 4'd0},
        {8'h18, 3'd4, 3'd0, 3'd4, 1'b0, 1'b0, 4'd1},
        {8'h18, 3'd4, 3'd0, 3'd3, 1'b0, 1'b0, 4'd0},
        {8'h24, 3'd1, 3'd1, 3'd0, 1'b0, 1'b0, 4'd1},
        {8'h3c, 3'd2, 3'd1, 3'd0, 1'b0, 1'b0, 4'd0},
        {8'h04, 3'd0, 3'd7, 3'd0, 1'b0, 1'b0, 4'd4},
        {8'h00, 3'd0, 3'd4, 3'd4, 1'b1, 1'b1, 4'd0}
    };

    string vtag [NV] = '{
        "R2", "R2", "R2", "R2", "R2", "R3", "R3", "R3", "R3", "R3",
        "R3", "R4", "R4", "R6", "R6", "R6", "R6", "R11", "R3"
    };

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] m, input logic [2:0] t, input logic [2:0] l,
                         input logic [2:0] c, input logic b, input logic e);
        sel_mask = m; thresh = t; legacy_uops = l; cache_uops = c; ms_busy = b; q_empty = e;
    endtask

    // Pulse clear for one cycle, leaving other inputs as they are
    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        exp_total = '0;
    endtask

    initial begin
        #(4 * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset count", count, 48'd0);

        // Table walk, plain uop/cycle counting
        en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            logic [7:0] m; logic [2:0] t, l, c; logic b, e; logic [3:0] inc;
            {m, t, l, c, b, e, inc} = VEC[i];
            drive(m, t, l, c, b, e);
            @(negedge clk);
            exp_total = exp_total + 48'(inc);
            check(vtag[i], count, exp_total);
        end

        // R5: threshold 0 accumulates over several cycles
        drive(8'h3c, 3'd0, 3'd2, 3'd1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        exp_total = exp_total + 48'd9;
        check("R5 accumulate", count, exp_total);

        // R8: clear wins over a live increment
        do_clear();
        check("R8 clear priority", count, 48'd0);

        // R9: disabled hold
        en = 1'b0;
        drive(8'h3c, 3'd0, 3'd4, 3'd4, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check("R9 hold while disabled", count, 48'd0);

        // R7: edge mode on busy deliveries
        en = 1'b1; edge_en = 1'b1;
        drive(8'h30, 3'd1, 3'd2, 3'd0, 1'b1, 1'b0);
        @(negedge clk);
        check("R7 first edge", count, 48'd1);
        drive(8'h30, 3'd1, 3'd0, 3'd1, 1'b1, 1'b0);
        @(negedge clk);
        check("R7 no recount while high", count, 48'd1);
        drive(8'h30, 3'd1, 3'd4, 3'd0, 1'b0, 1'b0);
        @(negedge clk);
        check("R7 quiet cycle", count, 48'd1);
        drive(8'h30, 3'd1, 3'd1, 3'd0, 1'b1, 1'b0);
        @(negedge clk);
        check("R7 second edge", count, 48'd2);

        // R9: disable during a high episode resets history
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        check("R9 edge after re-enable", count, 48'd3);

        // R8: clear keeps history high
        do_clear();
        @(negedge clk);
        check("R8 history kept over clear", count, 48'd0);

        // R7: threshold 0 in edge mode acts as 1
        drive(8'h30, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0);
        @(negedge clk);
        drive(8'h30, 3'd0, 3'd3, 3'd0, 1'b1, 1'b0);
        @(negedge clk);
        check("R7 zero threshold edge", count, 48'd1);

        // R10: narrow instance wraps
        edge_en = 1'b0;
        drive(8'h3c, 3'd0, 3'd4, 3'd4, 1'b0, 1'b0);
        do_clear();
        repeat (7) @(negedge clk);
        check("R10 before wrap", 48'(count_n), 48'd56);
        @(negedge clk);
        check("R10 wrapped", 48'(count_n), 48'd0);
        check("R10 wide no wrap", count, 48'd64);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule